// File: doc/BRIEF.md
# Acknowledged Rising-Edge Capture Latch

This block records that a digital input has gone from low to high and keeps that record until software clears it. The input is looked at only when a one-cycle sample strobe arrives. The strobe period sets how finely edges are resolved, and the intended period is 200 µs. A rising edge is seen when the value sampled at one strobe is 1 and the value held from the previous strobe is 0.

The stored flag is a set/clear memory in which the clear wins. A detected edge sets the flag. The acknowledge input clears it in any clock cycle. While acknowledge stays high, the flag is held at 0 and any edge detected during that time is discarded. Input debouncing and register-map placement are handled elsewhere. The block takes a clean single-bit input and drives a single status bit.

Top module: `edge_capture_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `edge_flag` to 0 and clears the stored previous sample to 0.
- R2: When `sample_tick` is 1, `din` is 1, the previous sample is 0 and `ack` is 0, `edge_flag` is 1 after that clock edge.
- R3: `din` is looked at only in cycles where `sample_tick` is 1. A high pulse that begins and ends between two strobes sets nothing.
- R4: A `din` that stays high across several strobes gives only one edge. Once the flag has been cleared, it stays 0 while the input stays high.
- R5: A falling edge, where the sample is 0 and the previous sample is 1, never sets `edge_flag`.
- R6: When `ack` is 0 and no edge is detected, `edge_flag` keeps its value.
- R7: When `ack` is 1 at a clock edge, `edge_flag` is 0 after that edge.
- R8: An edge detected in a cycle where `ack` is 1 is lost. The flag is 0 after that edge, and it stays 0 after `ack` falls if `din` remains high.
- R9: An edge detected in the first cycle after `ack` has returned to 0 is captured.
- R10: Because of R1, the first strobe after reset that finds `din` at 1 counts as a rising edge, even if `din` was already high before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle strobe that enables sampling of `din` |
| din | input | 1 | Input to watch, already debounced |
| ack | input | 1 | Acknowledge: clears the flag and blocks new captures, active high |
| edge_flag | output | 1 | Sticky rising-edge status |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edge and that every input is stable around the rising clock edge. They also assume `sample_tick` is a single-cycle pulse. The bench drives all inputs on the falling edge and produces the strobe on a fixed divider, with a few directed strobes placed by hand. Random phases change `din` and `ack` at irregular points, so edges fall both on strobe cycles and between them, and acknowledge pulses overlap strobes.

// File: rtl/edge_latch_pkg.sv
package edge_latch_pkg;

  // Next state of a set/clear memory in which clear has priority.
  function automatic logic rs_next(input logic q, input logic set_i, input logic clr_i);
    logic n;
    if (clr_i)      n = 1'b0;
    else if (set_i) n = 1'b1;
    else            n = q;
    return n;
  endfunction

  // Rising edge between two consecutive strobe samples.
  function automatic logic rise_of(input logic now_s, input logic prev_s);
    return now_s & ~prev_s;
  endfunction

endpackage

// File: rtl/rise_sampler.sv
module rise_sampler
  import edge_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic rise_evt,
  output logic prev_q
);

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= 1'b0;
    else if (tick) prev_q <= din;
  end

  assign rise_evt = tick & rise_of(din, prev_q);

  // R3: the stored sample moves only on a strobe
  assert_sample_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(prev_q));

  // R2: a strobe stores the present input value
  assert_sample_taken_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (prev_q == $past(din)));

endmodule

// File: rtl/rs_hold_latch.sv
module rs_hold_latch
  import edge_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= rs_next(q, set_i, clr_i);
  end

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q);

  assert_set_takes_R2: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q));

  assert_both_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> !q);

endmodule

// File: rtl/edge_capture_latch.sv
module edge_capture_latch (
  input  logic clk,
  input  logic rst,
  input  logic sample_tick,
  input  logic din,
  input  logic ack,
  output logic edge_flag
);

  logic rise_evt;
  logic prev_q;

  rise_sampler u_smp (
    .clk      (clk),
    .rst      (rst),
    .tick     (sample_tick),
    .din      (din),
    .rise_evt (rise_evt),
    .prev_q   (prev_q)
  );

  rs_hold_latch u_lat (
    .clk   (clk),
    .rst   (rst),
    .set_i (rise_evt),
    .clr_i (ack),
    .q     (edge_flag)
  );

  // R5: the flag only comes up after a detected rise with no acknowledge
  assert_set_only_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_flag) |-> $past(rise_evt && !ack));

  // R1: reset leaves both stored bits clear
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!edge_flag && !prev_q));

endmodule

// File: tb/sim_edge_capture_latch.sv
module sim_edge_capture_latch;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_tick = 1'b0;
  logic din = 1'b0;
  logic ack = 1'b0;
  logic edge_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit m_flag = 1'b0;
  bit m_prev = 1'b0;

  edge_capture_latch u0 (
    .clk(clk), .rst(rst), .sample_tick(sample_tick),
    .din(din), .ack(ack), .edge_flag(edge_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench restatement of the requirements.
  function automatic bit exp_flag(bit f, bit prv, bit d, bit t, bit a);
    bit edge_seen;
    edge_seen = t && d && !prv;
    case ({a, edge_seen})
      2'b00:   return f;
      2'b01:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit exp, input string tag);
    n_checks++;
    if (edge_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: edge_flag=%b expected %b at %0t", tag, edge_flag, exp, $time);
    end
  endtask

  // Apply inputs for one clock edge, update the model, return at the falling edge.
  task automatic cyc(input bit r, input bit d, input bit t, input bit a);
    rst = r; din = d; sample_tick = t; ack = a;
    @(posedge clk);
    if (r) begin m_flag = 1'b0; m_prev = 1'b0; end
    else begin
      m_flag = exp_flag(m_flag, m_prev, d, t, a);
      if (t) m_prev = d;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit d, a;
    void'($urandom(32'h5EED_0017));
    @(negedge clk);
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    check(0, "R1");
    // R10: din already high across reset, first strobe still counts
    cyc(0, 1, 0, 0); check(0, "R3");
    cyc(0, 1, 1, 0); check(1, "R10");
    cyc(0, 1, 0, 1); check(0, "R7");
    // R4: staying high gives no new edge
    cyc(0, 1, 1, 0); cyc(0, 1, 1, 0); check(0, "R4");
    // R5: falling edge
    cyc(0, 0, 1, 0); check(0, "R5");
    // R3: pulse between strobes
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 1, 0); check(0, "R3");
    // R2: real edge
    cyc(0, 1, 1, 0); check(1, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
    check(1, "R6");
    cyc(0, 0, 1, 0); check(1, "R6");
    // R8: edge during acknowledge is lost
    cyc(0, 1, 1, 1); check(0, "R8");
    cyc(0, 1, 1, 0); cyc(0, 1, 1, 0); check(0, "R8");
    // R9: edge right after acknowledge falls
    cyc(0, 0, 1, 1); cyc(0, 0, 0, 1); cyc(0, 1, 1, 0); check(1, "R9");
    // R1: reset mid-run with flag set and prev high
    cyc(1, 1, 0, 0); check(0, "R1");
    cyc(0, 1, 1, 0); check(1, "R1");
    cyc(0, 0, 1, 1); check(0, "R7");
    // random phase against the bench model
    for (int i = 0; i < 3000; i++) begin
      d = ($urandom_range(0, 3) == 0) ? ~din : din;
      a = ($urandom_range(0, 9) == 0);
      cyc(0, d, (i % TICK_DIV) == 0 || $urandom_range(0, 15) == 0, a);
      check(m_flag, "R2,R5,R6,R7,R8");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule